// File: doc/BRIEF.md
# Interprocessor Interrupt Command Sender

This block gives software a two-word command register through which one processor asks for an interrupt message to be sent to other processors. The upper word holds the target processor ID in its top byte. The lower word holds the interrupt vector, the delivery mode and a destination shorthand. Writing the lower word while the sender is idle launches the message.

Once launched, the message waits on a valid/ready output until the message network accepts it. A delivery-status bit in the lower word reads busy for that whole time. Software polls the bit and issues the next command only after it clears; a lower-word write made while busy is dropped.

The shorthand picks who receives the message. It can send to the ID held in the upper word, to this processor alone (its own ID is substituted), or to every processor with or without the sender (the broadcast ID is substituted). The interconnect, arbitration between senders and the receive side are outside this block.

Top module: `ipi_cmd_sender`

## Requirements
- R1: The upper command word (regAddr = 1) stores a destination ID in bits 31:24; its bits 23:0 always read as zero.
- R2: A write to the lower word (regAddr = 0) while idle raises msgValid in the next cycle, with msgVector = data[7:0], msgMode = data[10:8] and msgShorthand = data[19:18].
- R3: Lower-word bit 12 (delivery status) reads 1 from the cycle after a launch until the cycle after the message is accepted, and reads 0 otherwise.
- R4: While msgValid is high and msgReady is low, msgValid stays high and all message fields stay unchanged; msgValid falls in the cycle after a cycle with both high.
- R5: A lower-word write while delivery status is busy is ignored: the message fields and the stored lower-word fields do not change, and no second message follows.
- R6: Shorthand 0 sends to the upper-word ID, shorthand 1 sends to selfId, and shorthands 2 (all including self) and 3 (all excluding self) put the broadcast ID 8'hFF on msgDest.
- R7: The reserved lower-word bits (all bits except 7:0, 10:8, 12 and 19:18) always read as zero, whatever software writes to them.
- R8: After reset the sender is idle, msgValid is low and both command words read as zero.
- R9: An upper-word write while a message is pending does not change the msgDest of that message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selfId | input | 8 | ID of this processor |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = lower command word, 1 = upper command word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| msgValid | output | 1 | Message pending |
| msgReady | input | 1 | Message accepted by the network |
| msgVector | output | 8 | Interrupt vector |
| msgMode | output | 3 | Delivery mode |
| msgShorthand | output | 2 | Destination shorthand |
| msgDest | output | 8 | Resolved destination ID |

## Verification
A lower-word write seen at one clock edge shows up one edge later: msgValid, the message fields and status bit 12 all change after that edge. An accepting edge (valid and ready both high) makes msgValid and the status bit fall after that same edge. Reads go through combinational paths, so the bench drives every input and samples every output at the falling edge. Each result is therefore checked half a cycle after the rising edge that produces it. Ignored writes and late upper-word writes are checked while the message is held. The bench then watches one further cycle after acceptance to confirm that no second message appears.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int VecW    = 8;
  localparam int ModeW   = 3;
  localparam int ShW     = 2;
  localparam int IdW     = 8;
  localparam int WordW   = 32;
  localparam int ModeLsb = 8;
  localparam int BusyBit = 12;
  localparam int ShLsb   = 18;
  localparam int IdLsb   = WordW - IdW;
  localparam logic [IdW-1:0] BcastId = '1;

  typedef enum logic [ShW-1:0] {
    ShDest    = 2'd0,
    ShSelf    = 2'd1,
    ShAllIncl = 2'd2,
    ShAllExcl = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic launch;
    logic retire;
  } ctrlStrobe_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrLow,
  input  logic        msgReady,
  output logic        busy,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.launch = wrLow && !busy;
    strobe.retire = busy && msgReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              busy <= 1'b0;
    else if (strobe.launch) busy <= 1'b1;
    else if (strobe.retire) busy <= 1'b0;
  end

  assert_launch_sets_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrLow && !busy) |=> busy);
  assert_accept_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && msgReady) |=> !busy);
  assert_hold_until_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !msgReady) |=> busy);
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             busy,
  input  logic             msgReady,
  input  logic [IdW-1:0]   selfId,
  input  logic             wrHigh,
  input  logic             regAddr,
  input  logic [WordW-1:0] regWrData,
  output logic [WordW-1:0] regRdData,
  output logic [VecW-1:0]  msgVector,
  output logic [ModeW-1:0] msgMode,
  output logic [ShW-1:0]   msgShorthand,
  output logic [IdW-1:0]   msgDest
);
  logic [IdW-1:0] hiDest;
  logic [IdW-1:0] resolvedDest;
  shorthand_e     newSh;

  always_comb begin
    newSh = shorthand_e'(regWrData[ShLsb +: ShW]);
    case (newSh)
      ShDest:  resolvedDest = hiDest;
      ShSelf:  resolvedDest = selfId;
      default: resolvedDest = BcastId;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiDest       <= '0;
      msgVector    <= '0;
      msgMode      <= '0;
      msgShorthand <= '0;
      msgDest      <= '0;
    end else begin
      if (wrHigh) hiDest <= regWrData[IdLsb +: IdW];
      if (strobe.launch) begin
        msgVector    <= regWrData[0 +: VecW];
        msgMode      <= regWrData[ModeLsb +: ModeW];
        msgShorthand <= regWrData[ShLsb +: ShW];
        msgDest      <= resolvedDest;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr) begin
      regRdData[IdLsb +: IdW] = hiDest;
    end else begin
      regRdData[0 +: VecW]        = msgVector;
      regRdData[ModeLsb +: ModeW] = msgMode;
      regRdData[BusyBit]          = busy;
      regRdData[ShLsb +: ShW]     = msgShorthand;
    end
  end

  assert_fields_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !msgReady) |=> ($stable(msgVector) && $stable(msgMode)
                             && $stable(msgShorthand) && $stable(msgDest)));
  assert_self_dest_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.launch && regWrData[ShLsb +: ShW] == 2'd1) |=> (msgDest == $past(selfId)));
  assert_bcast_dest_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.launch && regWrData[ShLsb+1]) |=> (msgDest == BcastId));
endmodule

// File: rtl/ipi_cmd_sender.sv
module ipi_cmd_sender
  import ipi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  selfId,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        msgValid,
  input  logic        msgReady,
  output logic [7:0]  msgVector,
  output logic [2:0]  msgMode,
  output logic [1:0]  msgShorthand,
  output logic [7:0]  msgDest
);
  ctrlStrobe_t strobe;
  logic        busy;
  logic        wrLow;
  logic        wrHigh;

  assign wrLow    = regWrEn && !regAddr;
  assign wrHigh   = regWrEn && regAddr;
  assign msgValid = busy;

  ipi_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrLow(wrLow), .msgReady(msgReady),
    .busy(busy), .strobe(strobe)
  );

  ipi_datapath uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .msgReady(msgReady),
    .selfId(selfId), .wrHigh(wrHigh), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .msgVector(msgVector), .msgMode(msgMode),
    .msgShorthand(msgShorthand), .msgDest(msgDest)
  );

  assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && wrLow && !msgReady) |=> ($stable(msgVector) && $stable(msgShorthand)));
endmodule

// File: tb/tb_ipi_cmd_sender.sv
`timescale 1ns/1ps
module tb_ipi_cmd_sender;
  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  selfId = 8'h5A;
  logic        regWrEn = 0;
  logic        regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic        msgValid;
  logic        msgReady = 0;
  logic [7:0]  msgVector;
  logic [2:0]  msgMode;
  logic [1:0]  msgShorthand;
  logic [7:0]  msgDest;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipi_cmd_sender dut (.*);

  localparam logic [31:0] LowMask = 32'h000C07FF;

  function automatic logic [7:0] expDest(logic [1:0] sh, logic [7:0] hi, logic [7:0] me);
    if (sh == 2'd0) return hi;
    if (sh == 2'd1) return me;
    return 8'hFF;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic addr, logic [31:0] data);
    @(negedge clk);
    regWrEn = 1; regAddr = addr; regWrData = data;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic readReg(logic addr, output logic [31:0] data);
    regAddr = addr;
    #1 data = regRdData;
  endtask

  task automatic checkMsg(string req, logic [31:0] lo, logic [7:0] hiId);
    logic [31:0] rd;
    chk({req, " valid"}, 32'(msgValid), 32'd1);
    chk({req, " vector"}, 32'(msgVector), 32'(lo[7:0]));
    chk({req, " mode"}, 32'(msgMode), 32'(lo[10:8]));
    chk({req, " shorthand"}, 32'(msgShorthand), 32'(lo[19:18]));
    chk({req, " R6 dest"}, 32'(msgDest), 32'(expDest(lo[19:18], hiId, selfId)));
    readReg(0, rd);
    chk({req, " R3 R7 low readback busy"}, rd, (lo & LowMask) | 32'h1000);
  endtask

  task automatic sendAndCheck(logic [31:0] hi, logic [31:0] lo, int hold, bit poke);
    logic [31:0] rd;
    writeReg(1, hi);
    readReg(1, rd);
    chk("R1 high readback", rd, {hi[31:24], 24'h0});
    writeReg(0, lo);
    checkMsg("R2", lo, hi[31:24]);
    if (poke) begin
      writeReg(0, ~lo);
      checkMsg("R5", lo, hi[31:24]);
      writeReg(1, ~hi);
      checkMsg("R9", lo, hi[31:24]);
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      checkMsg("R4", lo, hi[31:24]);
    end
    msgReady = 1;
    @(posedge clk);
    @(negedge clk);
    msgReady = 0;
    chk("R4 valid falls", 32'(msgValid), 32'd0);
    readReg(0, rd);
    chk("R3 status clear", rd, lo & LowMask);
    @(negedge clk);
    chk("R5 no second message", 32'(msgValid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    chk("R8 reset valid", 32'(msgValid), 32'd0);
    readReg(0, rd); chk("R8 reset low", rd, 32'd0);
    readReg(1, rd); chk("R8 reset high", rd, 32'd0);
    readReg(0, rd);

    sendAndCheck(32'h3300_0000, 32'h0000_0041, 0, 0);
    sendAndCheck(32'h3300_0000, 32'h0004_0142, 2, 1);
    sendAndCheck(32'h7700_0000, 32'h0008_0043, 1, 1);
    sendAndCheck(32'h1100_0000, 32'h000C_0544, 3, 0);
    sendAndCheck(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);

    for (int t = 0; t < 200; t++) begin
      logic [31:0] hi, lo;
      hi = $urandom;
      lo = $urandom;
      selfId = 8'($urandom);
      sendAndCheck(hi, lo, int'($urandom % 5), bit'($urandom % 2));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule